// File: doc/BRIEF.md
# Multi-Queue Transmit Channel Scheduler

This block selects which transmit descriptor to hand out next. It serves sixteen circular descriptor queues, and each queue has a host-owned 8-bit write index and an 8-bit read index that the scheduler owns. Every queue is bound to one of eight transmit channels. Several queues may share a channel. Each channel has its own request port. The port offers the number of the chosen queue and that queue's current read index. When the downstream fetch engine accepts the offer with a grant pulse, the read index of that queue steps forward by one, wrapping modulo 256.

Software configures each queue through a masked status word. The upper ten bits of that word decide which of the lower ten bits take effect. A global empty-flag word works the same way: its upper half masks its lower half. An 8-bit channel enable word gates all requests. A queue runs in one of two modes. In strict in-order mode it hands out descriptors one after another. In windowed mode at most 64 descriptors may be outstanding; a completion pulse retires one of them. Among the eligible queues bound to the same channel, a round-robin arbiter picks one per cycle.

Top module: `txq_sched`

## Requirements
- R1: After reset, every queue is inactive with read and write indices of 0 and its empty flag set, all channels are disabled, and no request is valid.
- R2: A status write to a queue updates bit k (k = 0..9) of the status word only when bit k+10 of the same write is 1. Bit 0 is queue active, bits 4:1 are the channel number (the low 3 bits are used), bit 5 is window-space-left, and bit 8 selects windowed mode (1) or in-order mode (0).
- R3: A channel raises a request only while its bit in the 8-bit channel enable word is 1. Bit c enables channel c.
- R4: A queue is eligible when it is active, its empty flag is clear and its read index differs from its write index. A channel requests whenever at least one eligible queue is bound to it.
- R5: An empty-word write sets the empty flag of queue q to bit q only where bit q+16 is 1. Flags whose mask bit is 0 are unchanged. A set flag blocks requests.
- R6: A request carries the selected queue number and that queue's read index. A grant while the request is valid advances that read index by one, modulo 256 (255 wraps to 0).
- R7: A grant that moves the read index onto the write index sets the queue's empty flag. A write-index write clears the flag unless the new value equals the read index.
- R8: Queues that share a channel are served round-robin, starting from the queue after the one granted last on that channel.
- R9: A windowed-mode queue is eligible only with window-space-left set and fewer than 64 descriptors outstanding. Each grant adds one outstanding descriptor, and each completion pulse for the queue removes one.
- R10: Channels arbitrate independently, so grants on several channels in the same cycle each advance their own queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chen_we | input | 1 | Write strobe for the channel enable word |
| chen_wdata | input | 8 | Channel enable bits, one per channel |
| st_we | input | 1 | Write strobe for a queue status word |
| st_queue | input | 4 | Queue addressed by the status write |
| st_wdata | input | 20 | Status write: bits 19:10 mask, bits 9:0 value |
| wp_we | input | 1 | Write strobe for a queue write index |
| wp_queue | input | 4 | Queue addressed by the write-index write |
| wp_data | input | 8 | New write index |
| rp_we | input | 1 | Write strobe for a queue read index (initialisation) |
| rp_queue | input | 4 | Queue addressed by the read-index write |
| rp_data | input | 8 | New read index |
| emp_we | input | 1 | Write strobe for the empty-flag word |
| emp_wdata | input | 32 | Bits 31:16 mask, bits 15:0 empty flags |
| done_valid | input | 1 | Completion pulse for one windowed descriptor |
| done_queue | input | 4 | Queue the completion belongs to |
| req_grant | input | 8 | Per-channel acceptance of the current request |
| req_valid | output | 8 | Per-channel request valid |
| req_queue | output | 32 | Per-channel selected queue, 4 bits per channel |
| req_index | output | 64 | Per-channel read index of the selected queue, 8 bits per channel |
| rd_idx_o | output | 128 | Read index of every queue, 8 bits per queue |
| empty_o | output | 16 | Empty flag of every queue |

## Verification
The assertions check several rules on every cycle. A request appears only on an enabled channel. A channel with an eligible queue always requests, and the queue it offers is eligible. A grant reaches only an eligible queue and steps its read index by exactly one. Draining a queue sets its empty flag. An all-zero status mask leaves the status unchanged, and the outstanding count never passes 64. Other properties only the bench scenarios can show. These are the round-robin order between queues that share a channel, the exact sequence of indices across the 255-to-0 wrap, a windowed queue stalling after its 64th grant and resuming after a completion, and two channels being granted in the same cycle.

// File: rtl/txs_pkg.sv
package txs_pkg;
  // Status word layout: value bits and the offset of their write masks.
  localparam int ST_W      = 10;
  localparam int ST_ACT    = 0;
  localparam int ST_CH     = 1;
  localparam int ST_WSL    = 5;
  localparam int ST_WINMD  = 8;
  localparam int ST_MSK_LO = ST_W;
endpackage

// File: rtl/txs_qstate.sv
module txs_qstate
  import txs_pkg::*;
#(
  parameter int IDXW = 8,
  parameter int WIN  = 64,
  parameter int CHW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_we,
  input  logic [2*ST_W-1:0] st_wdata,
  input  logic              wp_we,
  input  logic [IDXW-1:0]   wp_data,
  input  logic              rp_we,
  input  logic [IDXW-1:0]   rp_data,
  input  logic              emp_we,
  input  logic              emp_mask,
  input  logic              emp_val,
  input  logic              grant,
  input  logic              done,
  output logic              ready,
  output logic [CHW-1:0]    chan,
  output logic [IDXW-1:0]   rd_idx,
  output logic              empty
);
  localparam int CW = $clog2(WIN + 1);

  logic [ST_W-1:0] st_q, st_n;
  logic [IDXW-1:0] rd_q, rd_n, wr_q, wr_n, rd_inc;
  logic            emp_q, emp_n;
  logic [CW-1:0]   infl_q, infl_n;
  logic            win_mode, win_room, unused_st;

  assign rd_inc    = rd_q + 1'b1;
  assign win_mode  = st_q[ST_WINMD];
  assign win_room  = st_q[ST_WSL] && (infl_q < CW'(WIN));
  assign unused_st = ^st_q;

  always_comb begin
    st_n = st_q;
    if (st_we)
      st_n = (st_q & ~st_wdata[ST_MSK_LO +: ST_W]) |
             (st_wdata[ST_W-1:0] & st_wdata[ST_MSK_LO +: ST_W]);

    rd_n = rd_q;
    if (grant) rd_n = rd_inc;
    if (rp_we) rd_n = rp_data;

    wr_n = wr_q;
    if (wp_we) wr_n = wp_data;

    emp_n = emp_q;
    if (grant && (rd_inc == wr_q)) emp_n = 1'b1;
    if (emp_we && emp_mask)        emp_n = emp_val;
    if (wp_we)                     emp_n = (wp_data == rd_n);

    infl_n = infl_q;
    if (!win_mode)
      infl_n = '0;
    else if (grant && !(done && infl_q != '0))
      infl_n = infl_q + 1'b1;
    else if (!grant && done && infl_q != '0)
      infl_n = infl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      emp_q  <= 1'b1;
      infl_q <= '0;
    end else begin
      st_q   <= st_n;
      rd_q   <= rd_n;
      wr_q   <= wr_n;
      emp_q  <= emp_n;
      infl_q <= infl_n;
    end
  end

  assign ready  = st_q[ST_ACT] && !emp_q && (rd_q != wr_q) && (!win_mode || win_room);
  assign chan   = st_q[ST_CH +: CHW];
  assign rd_idx = rd_q;
  assign empty  = emp_q;

  // R4: a grant only ever reaches an eligible queue
  assert_grant_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ready);
  // R6: a grant steps the read index by exactly one, wrapping
  assert_rd_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !rp_we) |=> rd_q == IDXW'($past(rd_q) + 1'b1));
  // R7: draining the last descriptor sets the empty flag
  assert_empty_on_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !rp_we && !wp_we && !emp_we && (rd_q + 1'b1 == wr_q)) |=> emp_q);
  // R2: an all-zero mask leaves the status word untouched
  assert_masked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_wdata[ST_MSK_LO +: ST_W] == '0) |=> st_q == $past(st_q));
  // R9: the outstanding count never passes the window limit
  assert_window_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    infl_q <= CW'(WIN));
endmodule

// File: rtl/txs_rr_arb.sv
module txs_rr_arb #(
  parameter int NQ = 16,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] elig,
  input  logic          grant,
  output logic          valid,
  output logic [QW-1:0] sel
);
  logic [QW-1:0] last_q, last_n;

  always_comb begin
    valid = 1'b0;
    sel   = '0;
    for (int i = 1; i <= NQ; i++) begin
      int k;
      k = (int'(last_q) + i) % NQ;
      if (!valid && elig[QW'(k)]) begin
        valid = 1'b1;
        sel   = QW'(k);
      end
    end
    last_n = last_q;
    if (valid && grant) last_n = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_n;
  end

  // R8: the offered queue is one of the eligible ones
  assert_pick_eligible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> elig[sel]);
  // R4: any eligible queue makes the channel request
  assert_request_when_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |-> valid);
endmodule

// File: rtl/txq_sched.sv
module txq_sched
  import txs_pkg::*;
#(
  parameter int NQ   = 16,
  parameter int NCH  = 8,
  parameter int IDXW = 8,
  parameter int WIN  = 64,
  localparam int QW  = $clog2(NQ),
  localparam int CHW = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chen_we,
  input  logic [NCH-1:0]      chen_wdata,
  input  logic                st_we,
  input  logic [QW-1:0]       st_queue,
  input  logic [2*ST_W-1:0]   st_wdata,
  input  logic                wp_we,
  input  logic [QW-1:0]       wp_queue,
  input  logic [IDXW-1:0]     wp_data,
  input  logic                rp_we,
  input  logic [QW-1:0]       rp_queue,
  input  logic [IDXW-1:0]     rp_data,
  input  logic                emp_we,
  input  logic [2*NQ-1:0]     emp_wdata,
  input  logic                done_valid,
  input  logic [QW-1:0]       done_queue,
  input  logic [NCH-1:0]      req_grant,
  output logic [NCH-1:0]      req_valid,
  output logic [NCH*QW-1:0]   req_queue,
  output logic [NCH*IDXW-1:0] req_index,
  output logic [NQ*IDXW-1:0]  rd_idx_o,
  output logic [NQ-1:0]       empty_o
);
  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_sync;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  logic [NCH-1:0] chen_q, chen_n;
  always_comb begin
    chen_n = chen_q;
    if (chen_we) chen_n = chen_wdata;
  end
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) chen_q <= '0;
    else         chen_q <= chen_n;
  end

  logic [NQ-1:0]   q_ready, q_grant;
  logic [CHW-1:0]  q_chan [NQ];
  logic [IDXW-1:0] q_rd   [NQ];
  logic [QW-1:0]   ch_sel [NCH];
  logic [NQ-1:0]   ch_elig[NCH];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    txs_qstate #(.IDXW(IDXW), .WIN(WIN), .CHW(CHW)) u_qs (
      .clk     (clk),
      .rst_n   (rst_sn),
      .st_we   (st_we && st_queue == QW'(q)),
      .st_wdata(st_wdata),
      .wp_we   (wp_we && wp_queue == QW'(q)),
      .wp_data (wp_data),
      .rp_we   (rp_we && rp_queue == QW'(q)),
      .rp_data (rp_data),
      .emp_we  (emp_we),
      .emp_mask(emp_wdata[NQ + q]),
      .emp_val (emp_wdata[q]),
      .grant   (q_grant[q]),
      .done    (done_valid && done_queue == QW'(q)),
      .ready   (q_ready[q]),
      .chan    (q_chan[q]),
      .rd_idx  (q_rd[q]),
      .empty   (empty_o[q])
    );
    assign q_grant[q] = req_valid[q_chan[q]] && req_grant[q_chan[q]] &&
                        (ch_sel[q_chan[q]] == QW'(q));
    assign rd_idx_o[q*IDXW +: IDXW] = q_rd[q];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar q = 0; q < NQ; q++) begin : g_map
      assign ch_elig[c][q] = q_ready[q] && chen_q[c] && (q_chan[q] == CHW'(c));
    end
    txs_rr_arb #(.NQ(NQ)) u_arb (
      .clk  (clk),
      .rst_n(rst_sn),
      .elig (ch_elig[c]),
      .grant(req_grant[c]),
      .valid(req_valid[c]),
      .sel  (ch_sel[c])
    );
    assign req_queue[c*QW +: QW]     = ch_sel[c];
    assign req_index[c*IDXW +: IDXW] = q_rd[ch_sel[c]];

    // R3: a disabled channel never requests
    assert_chan_enabled_R3: assert property (@(posedge clk) disable iff (!rst_sn)
      req_valid[c] |-> chen_q[c]);
  end
endmodule

// File: tb/tb_txq_sched.sv
`timescale 1ns/1ps
module tb_txq_sched;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n;
  logic chen_we; logic [7:0] chen_wdata;
  logic st_we; logic [3:0] st_queue; logic [19:0] st_wdata;
  logic wp_we; logic [3:0] wp_queue; logic [7:0] wp_data;
  logic rp_we; logic [3:0] rp_queue; logic [7:0] rp_data;
  logic emp_we; logic [31:0] emp_wdata;
  logic done_valid; logic [3:0] done_queue;
  logic [7:0] req_grant, req_valid;
  logic [31:0] req_queue;
  logic [63:0] req_index;
  logic [127:0] rd_idx_o;
  logic [15:0] empty_o;

  txq_sched dut (.*);

  int tests = 0, fails = 0;

  typedef struct { int ch; int q; int idx; string tag; } exp_t;
  exp_t sb[$];

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compare each granted channel against the scoreboard.
  always @(negedge clk) begin
    for (int c = 0; c < 8; c++) begin
      if (rst_n && req_grant[c]) begin
        if (sb.size() == 0) chk("scoreboard underflow", c, -1);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " channel"}, c, e.ch);
          chk({e.tag, " valid"}, int'(req_valid[c]), 1);
          chk({e.tag, " queue"}, int'(req_queue[c*4 +: 4]), e.q);
          chk({e.tag, " index"}, int'(req_index[c*8 +: 8]), e.idx);
        end
      end
    end
  end

  task automatic expect_req(int ch, int q, int idx, string tag);
    exp_t e;
    e.ch = ch; e.q = q; e.idx = idx; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic pull(logic [7:0] m);
    @(posedge clk); #2 req_grant = m;
    @(posedge clk); #2 req_grant = '0;
  endtask

  task automatic wr_status(int q, logic [9:0] mask, logic [9:0] val);
    @(posedge clk); #2 st_we = 1; st_queue = 4'(q); st_wdata = {mask, val};
    @(posedge clk); #2 st_we = 0;
  endtask
  task automatic wr_wp(int q, int v);
    @(posedge clk); #2 wp_we = 1; wp_queue = 4'(q); wp_data = 8'(v);
    @(posedge clk); #2 wp_we = 0;
  endtask
  task automatic wr_rp(int q, int v);
    @(posedge clk); #2 rp_we = 1; rp_queue = 4'(q); rp_data = 8'(v);
    @(posedge clk); #2 rp_we = 0;
  endtask
  task automatic wr_chen(logic [7:0] v);
    @(posedge clk); #2 chen_we = 1; chen_wdata = v;
    @(posedge clk); #2 chen_we = 0;
  endtask
  task automatic wr_emp(logic [15:0] mask, logic [15:0] val);
    @(posedge clk); #2 emp_we = 1; emp_wdata = {mask, val};
    @(posedge clk); #2 emp_we = 0;
  endtask
  task automatic pulse_done(int q);
    @(posedge clk); #2 done_valid = 1; done_queue = 4'(q);
    @(posedge clk); #2 done_valid = 0;
  endtask

  function automatic int rd_of(int q);
    return int'(rd_idx_o[q*8 +: 8]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; chen_we = 0; chen_wdata = 0; st_we = 0; st_queue = 0; st_wdata = 0;
    wp_we = 0; wp_queue = 0; wp_data = 0; rp_we = 0; rp_queue = 0; rp_data = 0;
    emp_we = 0; emp_wdata = 0; done_valid = 0; done_queue = 0; req_grant = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 empty flags", int'(empty_o), 16'hFFFF);
    chk("R1 rd index q0", rd_of(0), 0);
    chk("R1 rd index q15", rd_of(15), 0);

    wr_chen(8'hFF);
    // queue 2: active, channel 3, in-order
    wr_status(2, 10'h11F, 10'h007);
    @(negedge clk);
    chk("R4 active but empty queue idle", int'(req_valid[3]), 0);
    wr_wp(2, 3);
    @(negedge clk);
    chk("R4 request raised", int'(req_valid[3]), 1);
    chk("R6 request queue", int'(req_queue[12 +: 4]), 2);
    for (int i = 0; i < 3; i++) begin
      expect_req(3, 2, i, "R6 in-order grant");
      pull(8'h08);
    end
    @(negedge clk);
    chk("R7 drained queue empty", int'(empty_o[2]), 1);
    chk("R7 drained queue idle", int'(req_valid[3]), 0);
    chk("R6 rd index after three grants", rd_of(2), 3);

    // R2: zero mask ignored; write index clears empty
    wr_status(2, 10'h000, 10'h000);
    wr_wp(2, 5);
    @(negedge clk);
    chk("R7 write index clears empty", int'(empty_o[2]), 0);
    chk("R2 unmasked write ignored", int'(req_valid[3]), 1);
    chk("R2 index kept", int'(req_index[24 +: 8]), 3);
    wr_status(2, 10'h001, 10'h000);
    @(negedge clk);
    chk("R2 masked active clear", int'(req_valid[3]), 0);
    wr_status(2, 10'h001, 10'h001);

    // R3 channel enable
    wr_chen(8'hF7);
    @(negedge clk);
    chk("R3 disabled channel idle", int'(req_valid[3]), 0);
    wr_chen(8'hFF);
    @(negedge clk);
    chk("R3 re-enabled channel", int'(req_valid[3]), 1);

    // R8 round robin: queue 5 also on channel 3
    wr_status(5, 10'h11F, 10'h007);
    wr_wp(5, 2);
    expect_req(3, 5, 0, "R8 rr first"); pull(8'h08);
    expect_req(3, 2, 3, "R8 rr second"); pull(8'h08);
    expect_req(3, 5, 1, "R8 rr third"); pull(8'h08);
    expect_req(3, 2, 4, "R8 rr fourth"); pull(8'h08);
    @(negedge clk);
    chk("R8 both drained", int'(req_valid[3]), 0);

    // R5 empty word
    wr_status(7, 10'h11F, 10'h001);
    wr_wp(7, 4);
    wr_emp(16'h0000, 16'hFFFF);
    @(negedge clk);
    chk("R5 unmasked flags ignored", int'(empty_o[7]), 0);
    chk("R5 request kept", int'(req_valid[0]), 1);
    wr_emp(16'h0080, 16'h0080);
    @(negedge clk);
    chk("R5 masked flag set", int'(empty_o[7]), 1);
    chk("R5 set flag blocks", int'(req_valid[0]), 0);
    chk("R5 other flag kept", int'(empty_o[2]), 1);
    wr_emp(16'h0080, 16'h0000);
    @(negedge clk);
    chk("R5 flag cleared", int'(req_valid[0]), 1);

    // R10 parallel channels
    wr_status(9, 10'h11F, 10'h003);
    wr_wp(9, 1);
    expect_req(0, 7, 0, "R10 channel 0");
    expect_req(1, 9, 0, "R10 channel 1");
    pull(8'h03);
    @(negedge clk);
    chk("R10 q7 advanced", rd_of(7), 1);
    chk("R10 q9 advanced", rd_of(9), 1);

    // R6 wrap
    wr_status(11, 10'h11F, 10'h005);
    wr_rp(11, 255);
    wr_wp(11, 1);
    expect_req(2, 11, 255, "R6 wrap 255"); pull(8'h04);
    expect_req(2, 11, 0, "R6 wrap 0"); pull(8'h04);
    @(negedge clk);
    chk("R6 rd index after wrap", rd_of(11), 1);

    // R9 windowed mode
    wr_status(12, 10'h13F, 10'h129);
    wr_wp(12, 100);
    for (int i = 0; i < 64; i++) begin
      expect_req(4, 12, i, "R9 window grant");
      pull(8'h10);
    end
    @(negedge clk);
    chk("R9 window full stalls", int'(req_valid[4]), 0);
    chk("R9 rd index at 64", rd_of(12), 64);
    pulse_done(12);
    @(negedge clk);
    chk("R9 completion reopens", int'(req_valid[4]), 1);
    chk("R9 next index", int'(req_index[32 +: 8]), 64);
    wr_status(12, 10'h020, 10'h000);
    @(negedge clk);
    chk("R9 no window space", int'(req_valid[4]), 0);

    chk("scoreboard drained", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule